// File: doc/BRIEF.md
# CMI Receive Line Decoder with Code-Rule Violation Flagging

This block sits behind a clock-and-data-recovery front end on a coded-mark-inversion (CMI) receive path. On every rising edge of the recovered bit clock it takes one received bit, given as its two half-bit levels (first half and second half). It turns that pair into an NRZ data bit. It also raises a flag on any bit that breaks the line code. A violation can sit on a coded 0 as well as on a coded 1. The flag always lands in the same output slot as the bit that caused it.

The input is a stream with a valid strobe. A cycle with `in_valid` low carries no bit: it neither decodes nor changes the mark-polarity state. The output is a matching valid-qualified stream at a fixed latency. The line cannot be stalled, so neither side has a ready signal and nothing applies back-pressure. A consumer must accept every cycle in which `out_valid` is high. Reset is asynchronous and active low. It empties the pipeline and forgets the expected mark polarity.

Top module: `cmi_rx_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `out_valid`, `out_data` and `out_crv` are all 0, even if valid bits are offered during reset.
- R2: A bit whose halves differ decodes to data 0. The low-then-high pair (first=0, second=1) is a clean 0, with `out_crv`=0.
- R3: A bit whose halves are equal decodes to data 1. A 1 whose level is the opposite of the previous 1 is clean and becomes the new expected polarity. 0 bits in between do not affect the polarity.
- R4: The first 1 after reset is never flagged, whichever level it has. Its level becomes the reference polarity.
- R5: A high-then-low pair (first=1, second=0) is output as data 0 with `out_crv`=1. It leaves the mark polarity unchanged.
- R6: A 1 at the same level as the previous 1 is output as data 1 with `out_crv`=1. It does not update the expected polarity, so a following opposite-level 1 is clean.
- R7: A cycle with `in_valid`=0 yields `out_valid`=0 in its output slot, `out_crv`=0, and no change to the polarity state.
- R8: A bit presented before rising edge k appears on the outputs after rising edge k+LAT_BITS-1 (LAT_BITS=2 by default). `out_crv` is high only in that bit's slot and only when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rec | input | 1 | Recovered bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when the half-bit pair carries a received bit |
| sym_first | input | 1 | Line level in the first half of the bit |
| sym_second | input | 1 | Line level in the second half of the bit |
| out_valid | output | 1 | High when out_data/out_crv carry a decoded bit |
| out_data | output | 1 | Decoded NRZ bit |
| out_crv | output | 1 | Code-rule violation flag for this output bit |

## Verification
The bound checker checks the following on every cycle:
- the decode stage's response to each input class (high-then-low zero, first mark, repeated-level mark);
- that the polarity state holds through a repeated mark;
- that the flag never appears without valid;
- that reset empties the output.

Some behaviours only the directed scenarios can show. These are the exact output slot after the full delay line, the polarity history carried across long runs of zeros and invalid gaps, and the clean opposite-level mark that follows a flagged one.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;
  typedef struct packed {
    logic valid;
    logic data;
    logic crv;
  } cmi_bit_t;

  localparam cmi_bit_t CMI_BIT_IDLE = '{valid: 1'b0, data: 1'b0, crv: 1'b0};
endpackage

// File: rtl/cmi_sym_classify.sv
module cmi_sym_classify
  import cmi_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     sym_first,
  input  logic     sym_second,
  output cmi_bit_t cls_q,
  output logic     pol_seen,
  output logic     pol_last
);
  cmi_bit_t cls_d;
  logic     seen_d, last_d;

  always_comb begin
    cls_d  = CMI_BIT_IDLE;
    seen_d = pol_seen;
    last_d = pol_last;
    if (in_valid) begin
      cls_d.valid = 1'b1;
      if (sym_first != sym_second) begin
        // zero symbol: legal only as low-then-high
        cls_d.data = 1'b0;
        cls_d.crv  = sym_first;
      end else begin
        cls_d.data = 1'b1;
        if (!pol_seen) begin
          seen_d = 1'b1;
          last_d = sym_first;
        end else if (sym_first == pol_last) begin
          cls_d.crv = 1'b1;
        end else begin
          last_d = sym_first;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q    <= CMI_BIT_IDLE;
      pol_seen <= 1'b0;
      pol_last <= 1'b0;
    end else begin
      cls_q    <= cls_d;
      pol_seen <= seen_d;
      pol_last <= last_d;
    end
  end
endmodule

// File: rtl/cmi_bit_delay.sv
module cmi_bit_delay
  import cmi_rx_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cmi_bit_t din,
  output cmi_bit_t dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      cmi_bit_t stage_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= CMI_BIT_IDLE;
          else if (i == 0) stage_q[i] <= din;
          else stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cmi_rx_decoder.sv
module cmi_rx_decoder
  import cmi_rx_pkg::*;
#(
  parameter int LAT_BITS = 2
) (
  input  logic clk_rec,
  input  logic rst_n,
  input  logic in_valid,
  input  logic sym_first,
  input  logic sym_second,
  output logic out_valid,
  output logic out_data,
  output logic out_crv
);
  localparam int EXTRA_STAGES = (LAT_BITS > 1) ? LAT_BITS - 1 : 0;

  cmi_bit_t cls_q, tail;
  logic     pol_seen, pol_last;
  logic     cls_valid, cls_data, cls_crv;

  cmi_sym_classify i_classify (
    .clk        (clk_rec),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sym_first  (sym_first),
    .sym_second (sym_second),
    .cls_q      (cls_q),
    .pol_seen   (pol_seen),
    .pol_last   (pol_last)
  );

  cmi_bit_delay #(.DEPTH(EXTRA_STAGES)) i_delay (
    .clk   (clk_rec),
    .rst_n (rst_n),
    .din   (cls_q),
    .dout  (tail)
  );

  assign cls_valid = cls_q.valid;
  assign cls_data  = cls_q.data;
  assign cls_crv   = cls_q.crv;

  assign out_valid = tail.valid;
  assign out_data  = tail.data;
  assign out_crv   = tail.crv;
endmodule

// File: rtl/cmi_rx_decoder_chk.sv
module cmi_rx_decoder_chk (
  input logic clk_rec,
  input logic rst_n,
  input logic in_valid,
  input logic sym_first,
  input logic sym_second,
  input logic cls_valid,
  input logic cls_data,
  input logic cls_crv,
  input logic pol_seen,
  input logic pol_last,
  input logic out_valid,
  input logic out_crv
);
  p_reset_empty_r1: assert property (@(posedge clk_rec)
    !rst_n |=> !out_valid);

  p_first_one_clean_r4: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (in_valid && sym_first == sym_second && !pol_seen) |=> (!cls_crv && cls_data && pol_seen));

  p_zero_violation_r5: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (in_valid && sym_first && !sym_second) |=> (cls_crv && !cls_data && $stable(pol_last)));

  p_repeat_one_hold_r6: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (in_valid && sym_first == sym_second && pol_seen && sym_first == pol_last)
      |=> (cls_crv && cls_data && $stable(pol_last)));

  p_idle_no_effect_r7: assert property (@(posedge clk_rec) disable iff (!rst_n)
    !in_valid |=> (!cls_valid && $stable(pol_last) && $stable(pol_seen)));

  p_stage_valid_r8: assert property (@(posedge clk_rec) disable iff (!rst_n)
    in_valid |=> cls_valid);

  p_crv_in_slot_r8: assert property (@(posedge clk_rec) disable iff (!rst_n)
    out_crv |-> out_valid);
endmodule

bind cmi_rx_decoder cmi_rx_decoder_chk i_chk (
  .clk_rec    (clk_rec),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sym_first  (sym_first),
  .sym_second (sym_second),
  .cls_valid  (cls_valid),
  .cls_data   (cls_data),
  .cls_crv    (cls_crv),
  .pol_seen   (pol_seen),
  .pol_last   (pol_last),
  .out_valid  (out_valid),
  .out_crv    (out_crv)
);

// File: tb/test_cmi_rx_decoder.sv
`timescale 1ns/1ps
module test_cmi_rx_decoder;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, sym_first = 1'b0, sym_second = 1'b0;
  logic out_valid, out_data, out_crv;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic  hv [0:1023];
  logic  hd [0:1023];
  logic  hc [0:1023];
  string ht [0:1023];
  int    s = 0;

  always #2 clk = ~clk;

  cmi_rx_decoder #(.LAT_BITS(LAT)) i_cmi_rx_decoder (
    .clk_rec(clk), .rst_n(rst_n), .in_valid(in_valid),
    .sym_first(sym_first), .sym_second(sym_second),
    .out_valid(out_valid), .out_data(out_data), .out_crv(out_crv)
  );

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // check output slot of step idx, then drive a new bit
  task automatic step(input logic v, input logic a, input logic b,
                      input logic ed, input logic ec, input string tag);
    @(negedge clk);
    if (s >= LAT) begin
      cmp("R8", "out_valid", out_valid, hv[s-LAT]);
      if (hv[s-LAT]) begin
        cmp(ht[s-LAT], "out_data", out_data, hd[s-LAT]);
        cmp(ht[s-LAT], "out_crv", out_crv, hc[s-LAT]);
      end else begin
        cmp("R7", "out_crv idle", out_crv, 1'b0);
      end
    end
    in_valid = v; sym_first = a; sym_second = b;
    hv[s] = v; hd[s] = ed; hc[s] = ec; ht[s] = tag;
    s++;
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1; sym_first = 1'b1; sym_second = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1", "out_valid in reset", out_valid, 1'b0);
    cmp("R1", "out_data in reset", out_data, 1'b0);
    cmp("R1", "out_crv in reset", out_crv, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "out_valid after release", out_valid, 1'b0);
    cmp("R1", "out_crv after release", out_crv, 1'b0);
    s = 0;
  endtask

  task automatic t_clean_zeros();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    flush();
  endtask

  task automatic t_first_one_high();
    t_reset();
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    flush();
  endtask

  task automatic t_alternating_marks();
    t_reset();
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    flush();
  endtask

  task automatic t_zero_violation();
    // polarity is high after the previous scenario
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    flush();
  endtask

  task automatic t_repeat_mark();
    // polarity is low now
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    flush();
  endtask

  task automatic t_idle_gap();
    // polarity is high; idle cycles with mark-like levels must not alter it
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    flush();
  endtask

  task automatic t_single_bit_latency();
    // a lone bit: its slot is exactly LAT edges later, idle around it
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    flush();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_clean_zeros();
    t_first_one_high();
    t_alternating_marks();
    t_zero_violation();
    t_repeat_mark();
    t_idle_gap();
    t_single_bit_latency();
    finish_run();
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule